// File: doc/BRIEF.md
# Pseudocolour Palette DAC

The block holds a colour lookup table of 260 entries, each a 24-bit red/green/blue triple. Entries 0 to 255 form the pixel palette; entries 256 to 259 form a small overlay bank used for cursor colours. A processor reaches the table through a 32-bit register window. It writes an entry number into an index register, then moves through the red, green and blue bytes of that entry with successive data accesses. After the blue byte the index steps on by itself, so a whole palette can be streamed without reloading the index.

A second, read-only port serves the display path. Each clock it takes an 8-bit pixel value, or a cursor colour select, and returns the matching 24-bit colour one clock later.

Top module: `pal_dac`

## Requirements
- R1: A full-word write at byte offset 0x0 loads the entry index from data bits 31:24 and sets the colour phase to red.
- R2: Colour bytes travel in data bits 31:24. Write data bits 23:0 are ignored. Read data returns the byte in bits 31:24 with bits 23:0 zero.
- R3: Each data access acts on red, then green, then blue of the current entry. An access on blue returns the phase to red and adds one to the index modulo 256, so index 255 steps to 0.
- R4: A full-word write at offset 0x4 stores the byte into the colour of main entry `index` that the current phase selects.
- R5: A full-word write at offset 0xC stores the byte into overlay entry 256 + index[1:0]. It uses the same phase sequence and index stepping, and leaves the main palette untouched.
- R6: A full-word read (cpu_re_i high, cpu_we_i low, cpu_be_i = 4'hF) at any offset returns the current phase's byte of main entry `index` on cpu_rdata_o one clock later and advances the sequence as in R3. cpu_rdata_o holds its value at all other times.
- R7: After reset, entries 255, 256 and 258 are white (0xFFFFFF) and every other entry is black. The index is 0, the phase is red and cpu_rdata_o is 0.
- R8: Writes at offset 0x8 or at any other undecoded offset, and any access whose byte enables are not 4'hF, change no entry, no index and no phase. A partial read also leaves cpu_rdata_o unchanged.
- R9: rgb_o is registered and shows {red, green, blue} one clock after the inputs. With lk_sel_i[1] = 0 it shows main entry lk_idx_i. lk_sel_i = 2'b10 selects entry 258 and 2'b11 selects entry 259.
- R10: When a processor write and a lookup address the same entry in the same clock, the lookup returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_we_i | input | 1 | Register write strobe |
| cpu_re_i | input | 1 | Register read strobe |
| cpu_addr_i | input | 4 | Byte offset inside the register window |
| cpu_be_i | input | 4 | Byte enables; only 4'hF is acted on |
| cpu_wdata_i | input | 32 | Write data |
| cpu_rdata_o | output | 32 | Registered read data |
| lk_idx_i | input | 8 | Pixel value to translate |
| lk_sel_i | input | 2 | Lookup source: pixel or overlay entry 258/259 |
| rgb_o | output | 24 | Registered colour {red, green, blue} |

## Verification
A register access takes effect at the clock edge that samples it. Read data and lookup colours both appear one edge after their request. The bench drives every input on the falling edge and checks on the next falling edge, which is one rising edge after the stimulus. The same-entry collision check samples twice: once at that first falling edge, where the old colour is due, and once a cycle later, where the new colour is due. Register side effects such as phase and index stepping are observed through later reads, not through internal state.

// File: rtl/pal_dac_pkg.sv
package pal_dac_pkg;
  parameter int COL_W    = 8;
  parameter int IDX_W    = 8;
  parameter int MAIN_N   = 1 << IDX_W;
  parameter int OVL_N    = 4;
  parameter int ENT_N    = MAIN_N + OVL_N;
  parameter int ENT_W    = $clog2(ENT_N);
  parameter int DATA_W   = 32;
  parameter int OFS_W    = 4;
  parameter int BE_W     = DATA_W / 8;
  parameter int RGB_W    = 3 * COL_W;

  parameter logic [OFS_W-1:0] OFS_INDEX = 4'h0;
  parameter logic [OFS_W-1:0] OFS_MAIN  = 4'h4;
  parameter logic [OFS_W-1:0] OFS_OVL   = 4'hC;

  typedef enum logic [1:0] {
    PH_RED = 2'd0,
    PH_GRN = 2'd1,
    PH_BLU = 2'd2
  } phase_e;

  function automatic logic [COL_W-1:0] reset_colour(int ent);
    return (ent == MAIN_N - 1 || ent == MAIN_N || ent == MAIN_N + 2)
           ? {COL_W{1'b1}} : '0;
  endfunction
endpackage

// File: rtl/pal_dac_plane.sv
module pal_dac_plane
  import pal_dac_pkg::*;
#(
  parameter int DEPTH = ENT_N,
  parameter int AW    = ENT_W,
  parameter int W     = COL_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_a_i,
  output logic [W-1:0]  rdata_a_o,
  input  logic [AW-1:0] raddr_b_i,
  output logic [W-1:0]  rdata_b_o
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= reset_colour(i);
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_a_o = mem_q[raddr_a_i];
  assign rdata_b_o = mem_q[raddr_b_i];
endmodule

// File: rtl/pal_dac_bank.sv
module pal_dac_bank
  import pal_dac_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  phase_e           wphase_i,
  input  logic [ENT_W-1:0] waddr_i,
  input  logic [COL_W-1:0] wbyte_i,
  input  phase_e           rphase_i,
  input  logic [ENT_W-1:0] raddr_i,
  output logic [COL_W-1:0] rbyte_o,
  input  logic [ENT_W-1:0] lk_addr_i,
  output logic [RGB_W-1:0] lk_rgb_o
);
  logic [COL_W-1:0] cpu_col [3];
  logic [COL_W-1:0] lk_col  [3];

  for (genvar c = 0; c < 3; c++) begin : g_plane
    pal_dac_plane #(.DEPTH(ENT_N), .AW(ENT_W), .W(COL_W)) u_plane (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .we_i     (we_i && (wphase_i == phase_e'(c))),
      .waddr_i  (waddr_i),
      .wdata_i  (wbyte_i),
      .raddr_a_i(raddr_i),
      .rdata_a_o(cpu_col[c]),
      .raddr_b_i(lk_addr_i),
      .rdata_b_o(lk_col[c])
    );
  end

  always_comb begin
    unique case (rphase_i)
      PH_GRN:  rbyte_o = cpu_col[1];
      PH_BLU:  rbyte_o = cpu_col[2];
      default: rbyte_o = cpu_col[0];
    endcase
  end

  assign lk_rgb_o = {lk_col[0], lk_col[1], lk_col[2]};
endmodule

// File: rtl/pal_dac_seq.sv
module pal_dac_seq
  import pal_dac_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [OFS_W-1:0]  addr_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic [COL_W-1:0]  wbyte_i,
  output logic [IDX_W-1:0]  idx_o,
  output phase_e            phase_o,
  output logic              ent_we_o,
  output logic [ENT_W-1:0]  ent_addr_o,
  output logic              rd_go_o
);
  logic       full;
  logic       ld_idx;
  logic       wr_main;
  logic       wr_ovl;
  logic       step;
  logic [IDX_W-1:0] idx_q;
  phase_e     phase_q;

  assign full    = (be_i == {BE_W{1'b1}});
  assign ld_idx  = we_i && full && (addr_i == OFS_INDEX);
  assign wr_main = we_i && full && (addr_i == OFS_MAIN);
  assign wr_ovl  = we_i && full && (addr_i == OFS_OVL);
  assign rd_go_o = re_i && !we_i && full;
  assign step    = wr_main || wr_ovl || rd_go_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q   <= '0;
      phase_q <= PH_RED;
    end else if (ld_idx) begin
      idx_q   <= wbyte_i;
      phase_q <= PH_RED;
    end else if (step) begin
      unique case (phase_q)
        PH_RED: phase_q <= PH_GRN;
        PH_GRN: phase_q <= PH_BLU;
        default: begin
          phase_q <= PH_RED;
          idx_q   <= idx_q + 1'b1;
        end
      endcase
    end
  end

  assign idx_o      = idx_q;
  assign phase_o    = phase_q;
  assign ent_we_o   = wr_main || wr_ovl;
  assign ent_addr_o = wr_ovl ? ENT_W'(MAIN_N + int'(idx_q[1:0]))
                             : ENT_W'(idx_q);
endmodule

// File: rtl/pal_dac_lookup.sv
module pal_dac_lookup
  import pal_dac_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [1:0]       sel_i,
  output logic [ENT_W-1:0] addr_o,
  input  logic [RGB_W-1:0] rgb_i,
  output logic [RGB_W-1:0] rgb_o
);
  // sel[1]: overlay tap, sel[0]: 258 vs 259
  assign addr_o = sel_i[1] ? ENT_W'(MAIN_N + 2 + int'(sel_i[0])) : ENT_W'(idx_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rgb_o <= '0;
    else         rgb_o <= rgb_i;
  end
endmodule

// File: rtl/pal_dac.sv
module pal_dac
  import pal_dac_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_we_i,
  input  logic              cpu_re_i,
  input  logic [OFS_W-1:0]  cpu_addr_i,
  input  logic [BE_W-1:0]   cpu_be_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic [DATA_W-1:0] cpu_rdata_o,
  input  logic [IDX_W-1:0]  lk_idx_i,
  input  logic [1:0]        lk_sel_i,
  output logic [RGB_W-1:0]  rgb_o
);
  localparam int BYTE_LSB = DATA_W - COL_W;

  logic [COL_W-1:0] wbyte;
  logic [IDX_W-1:0] seq_idx;
  phase_e           seq_phase;
  logic             ent_we;
  logic [ENT_W-1:0] ent_addr;
  logic             rd_go;
  logic [COL_W-1:0] rd_byte;
  logic [ENT_W-1:0] lk_addr;
  logic [RGB_W-1:0] lk_rgb;
  logic             unused_wdata_lo;

  assign wbyte           = cpu_wdata_i[DATA_W-1:BYTE_LSB];
  assign unused_wdata_lo = ^cpu_wdata_i[BYTE_LSB-1:0];

  pal_dac_seq u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (cpu_we_i),
    .re_i      (cpu_re_i),
    .addr_i    (cpu_addr_i),
    .be_i      (cpu_be_i),
    .wbyte_i   (wbyte),
    .idx_o     (seq_idx),
    .phase_o   (seq_phase),
    .ent_we_o  (ent_we),
    .ent_addr_o(ent_addr),
    .rd_go_o   (rd_go)
  );

  pal_dac_bank u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (ent_we),
    .wphase_i (seq_phase),
    .waddr_i  (ent_addr),
    .wbyte_i  (wbyte),
    .rphase_i (seq_phase),
    .raddr_i  (ENT_W'(seq_idx)),
    .rbyte_o  (rd_byte),
    .lk_addr_i(lk_addr),
    .lk_rgb_o (lk_rgb)
  );

  pal_dac_lookup u_lookup (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .idx_i (lk_idx_i),
    .sel_i (lk_sel_i),
    .addr_o(lk_addr),
    .rgb_i (lk_rgb),
    .rgb_o (rgb_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cpu_rdata_o <= '0;
    else if (rd_go) cpu_rdata_o <= {rd_byte, {BYTE_LSB{1'b0}}};
  end
endmodule

// File: rtl/pal_dac_chk.sv
module pal_dac_chk
  import pal_dac_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cpu_we_i,
  input logic              cpu_re_i,
  input logic [OFS_W-1:0]  cpu_addr_i,
  input logic [BE_W-1:0]   cpu_be_i,
  input logic [DATA_W-1:0] cpu_wdata_i,
  input logic [DATA_W-1:0] cpu_rdata_o,
  input logic [IDX_W-1:0]  idx_i,
  input logic [1:0]        phase_i
);
  logic full;
  assign full = (cpu_be_i == {BE_W{1'b1}});

  p_idx_load_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_we_i && full && cpu_addr_i == OFS_INDEX)
    |=> (idx_i == $past(cpu_wdata_i[DATA_W-1 -: IDX_W])) && (phase_i == 2'd0));

  p_blue_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full && phase_i == 2'd2 &&
     ((cpu_we_i && (cpu_addr_i == OFS_MAIN || cpu_addr_i == OFS_OVL)) ||
      (cpu_re_i && !cpu_we_i)))
    |=> (idx_i == IDX_W'($past(idx_i) + 1'b1)) && (phase_i == 2'd0));

  p_ovl_keep_idx_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_we_i && full && cpu_addr_i == OFS_OVL && phase_i != 2'd2)
    |=> $stable(idx_i));

  p_rdata_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cpu_re_i && !cpu_we_i && full) |=> $stable(cpu_rdata_o));

  p_rdata_low_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_rdata_o[DATA_W-COL_W-1:0] == '0);

  p_ignore_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!full || (cpu_we_i && cpu_addr_i != OFS_INDEX && cpu_addr_i != OFS_MAIN &&
               cpu_addr_i != OFS_OVL) || (!cpu_we_i && !cpu_re_i))
    |=> $stable(idx_i) && $stable(phase_i));

  p_phase_legal_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_i != 2'd3);
endmodule

bind pal_dac pal_dac_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cpu_we_i   (cpu_we_i),
  .cpu_re_i   (cpu_re_i),
  .cpu_addr_i (cpu_addr_i),
  .cpu_be_i   (cpu_be_i),
  .cpu_wdata_i(cpu_wdata_i),
  .cpu_rdata_o(cpu_rdata_o),
  .idx_i      (seq_idx),
  .phase_i    (seq_phase)
);

// File: tb/tb_pal_dac.sv
`timescale 1ns/1ps
module tb_pal_dac;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0, re = 1'b0;
  logic [3:0]  addr = '0;
  logic [3:0]  be = 4'hF;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  lk_idx = '0;
  logic [1:0]  lk_sel = '0;
  logic [23:0] rgb;

  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  pal_dac dut (
    .clk_i(clk), .rst_ni(rst_n), .cpu_we_i(we), .cpu_re_i(re),
    .cpu_addr_i(addr), .cpu_be_i(be), .cpu_wdata_i(wdata), .cpu_rdata_o(rdata),
    .lk_idx_i(lk_idx), .lk_sel_i(lk_sel), .rgb_o(rgb)
  );

  // vector: {is_read, offset, data, expected read data}
  localparam int NV = 20;
  localparam logic [68:0] VEC [NV] = '{
    {1'b0, 4'h0, 32'h0500_0000, 32'h0},  // R1 index 5
    {1'b0, 4'h4, 32'h11AB_CDEF, 32'h0},  // R2 low bits ignored
    {1'b0, 4'h4, 32'h2200_0000, 32'h0},
    {1'b0, 4'h4, 32'h3300_0000, 32'h0},  // R3 -> index 6
    {1'b0, 4'h4, 32'h4400_0000, 32'h0},  // R4 red of 6
    {1'b0, 4'h0, 32'h0500_0000, 32'h0},  // R1 back to 5, red
    {1'b1, 4'h4, 32'h0, 32'h1100_0000},  // R6 R2
    {1'b1, 4'h4, 32'h0, 32'h2200_0000},
    {1'b1, 4'h4, 32'h0, 32'h3300_0000},
    {1'b1, 4'h0, 32'h0, 32'h4400_0000},
    {1'b1, 4'h8, 32'h0, 32'h0000_0000},
    {1'b1, 4'h4, 32'h0, 32'h0000_0000},
    {1'b0, 4'h0, 32'hFE00_0000, 32'h0},  // index 254 -> overlay 258
    {1'b0, 4'hC, 32'h1000_0000, 32'h0},  // R5
    {1'b0, 4'hC, 32'h2000_0000, 32'h0},
    {1'b0, 4'hC, 32'h3000_0000, 32'h0},  // -> index 255
    {1'b1, 4'hC, 32'h0, 32'hFF00_0000},  // R7 white 255, R6 main bank
    {1'b1, 4'h4, 32'h0, 32'hFF00_0000},
    {1'b1, 4'h4, 32'h0, 32'hFF00_0000},  // R3 wrap to 0
    {1'b1, 4'h4, 32'h0, 32'h0000_0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cpu_wr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] b);
    @(negedge clk); we = 1'b1; addr = a; wdata = d; be = b;
    @(negedge clk); we = 1'b0; be = 4'hF;
  endtask

  task automatic cpu_rd(input logic [3:0] a, input logic [3:0] b, input string req,
                        input logic [31:0] exp);
    @(negedge clk); re = 1'b1; addr = a; be = b;
    @(negedge clk); re = 1'b0; be = 4'hF;
    check(req, rdata, exp);
  endtask

  task automatic look(input logic [7:0] i, input logic [1:0] s, input string req,
                      input logic [23:0] exp);
    @(negedge clk); lk_idx = i; lk_sel = s;
    @(negedge clk);
    check(req, {8'h0, rgb}, {8'h0, exp});
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R7 rdata", rdata, 32'h0);
    look(8'd0,   2'b00, "R7 entry0",   24'h000000);
    look(8'd255, 2'b00, "R7 entry255", 24'hFFFFFF);
    look(8'd0,   2'b10, "R9 R7 ent258", 24'hFFFFFF);
    look(8'd0,   2'b11, "R9 R7 ent259", 24'h000000);

    for (int v = 0; v < NV; v++) begin
      if (VEC[v][68])
        cpu_rd(VEC[v][67:64], 4'hF, $sformatf("R6 vec%0d", v), VEC[v][31:0]);
      else
        cpu_wr(VEC[v][67:64], VEC[v][63:32], 4'hF);
    end

    look(8'd5,   2'b00, "R4 R9 entry5",  24'h112233);
    look(8'd6,   2'b01, "R9 sel01 pixel", 24'h440000);
    look(8'd0,   2'b10, "R5 ent258",     24'h102030);
    look(8'd254, 2'b00, "R5 main254",    24'h000000);

    // R8: ignored offset and partial accesses
    cpu_wr(4'h0, 32'h0500_0000, 4'hF);
    cpu_wr(4'h8, 32'hAA00_0000, 4'hF);
    cpu_wr(4'h4, 32'h9900_0000, 4'h3);
    cpu_rd(4'h4, 4'hF, "R8 no step", 32'h1100_0000);
    cpu_rd(4'h4, 4'h1, "R8 partial read", 32'h1100_0000);
    cpu_rd(4'h4, 4'hF, "R8 read no step", 32'h2200_0000);
    look(8'd5, 2'b00, "R8 entry5 kept", 24'h112233);

    // R10: write and lookup to entry 9 in the same cycle
    cpu_wr(4'h0, 32'h0900_0000, 4'hF);
    @(negedge clk);
    we = 1'b1; addr = 4'h4; wdata = 32'h7700_0000; lk_idx = 8'd9; lk_sel = 2'b00;
    @(negedge clk);
    we = 1'b0;
    check("R10 old value", {8'h0, rgb}, 32'h0);
    @(negedge clk);
    check("R10 new value", {8'h0, rgb}, 32'h0077_0000);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule